// File: doc/BRIEF.md
# Interlaced Frame DMA Address Generator

This block produces the burst addresses for one DMA channel whose frame is stored as several interleaved fields. A start pulse captures the configuration into working registers. The configuration is a field base address, a field count, a lines-per-field count, a line width in bytes, a gap in bytes skipped after each line, a bursts-per-request code and a total byte count. From then on, every accepted transfer request produces one, two or four 16-byte burst addresses on consecutive cycles.

Inside a line the address rises by 16 per burst. When a line ends, the gap is added before the next line begins. When the last line of a field ends, the field base moves forward by one line width and the next field starts there. This places successive fields on interleaved lines. The transfer ends when the byte budget or the field count runs out. At that point a sticky DONE flag is set, which software clears by writing a one.

The controller has three states. `S_IDLE` goes to `S_ARMED` on a start pulse with a valid configuration. `S_ARMED` goes to `S_ISSUE` on a request. `S_ISSUE` returns to `S_ARMED` after the last burst of the request, or to `S_IDLE` when the transfer ends, which may happen in the middle of a request.

Top module: `ilv_addr_gen`

## Requirements
- R1: A start pulse in `S_IDLE` with a valid configuration makes `busy` high from the next cycle. `busy` stays high until the cycle in which `done` rises.
- R2: An accepted request drives `burst_valid` high starting the cycle after `req` is sampled, for exactly N consecutive cycles. N is 1 for code 2'b00, 2 for 2'b01, 4 for 2'b11, and 1 for the reserved code 2'b10.
- R3: The first burst of a transfer is at the field base. Within a line, each burst address is the previous one plus 16.
- R4: After the last burst of a line that is not the last line of its field, the next address is that burst's address plus 16 plus the gap byte count.
- R5: After the last line of a field, the field base increases by the line width. The next burst is issued at the new base, and the line count starts again at the lines-per-field value.
- R6: The transfer ends after the last burst of the field whose completion brings the field count to zero.
- R7: Each burst consumes 16 bytes of the total. The transfer ends after floor(total/16) bursts, even if that falls in the middle of a request.
- R8: When the transfer ends, `done` rises and `busy` falls in the same cycle. A write with bit 1 clears `done`. A write with bit 0 leaves it unchanged.
- R9: A start in `S_IDLE` sets `cfg_err` and does not start the transfer if any of these hold: the line width is zero; the line width is not a multiple of 16 (codes 00 and 10), 32 (code 01) or 64 (code 11); the lines or fields count is zero; the total is below 16. Any start in `S_IDLE` updates `cfg_err`.
- R10: A request is ignored outside `S_ARMED`, both while idle and while a request is being issued. An ignored request produces no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_field_base | input | 32 | Base address of the first field |
| cfg_num_fields | input | 16 | Fields per frame |
| cfg_lines_per_field | input | 16 | Lines in each field |
| cfg_line_bytes | input | 16 | Bytes per line |
| cfg_gap_bytes | input | 16 | Bytes skipped after each line |
| cfg_burst_code | input | 2 | Bursts-per-request code |
| cfg_total_bytes | input | 32 | Total bytes to move |
| start | input | 1 | Load configuration and begin |
| req | input | 1 | Transfer request |
| done_clr_wr | input | 1 | Status write strobe |
| done_clr_bit | input | 1 | Write data for DONE (1 clears) |
| burst_valid | output | 1 | A burst address is presented |
| burst_addr | output | 32 | Current burst address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |
| cfg_err | output | 1 | Last start rejected |

## Verification
All outputs are registered-state decodes. A start is therefore visible on `busy` or `cfg_err` one cycle after its sampling edge. The first burst of a request appears one cycle after `req` is sampled, and later bursts follow one per cycle. `done` rises and `busy` falls one cycle after the edge that consumes the final burst. A DONE write takes effect one cycle after it is sampled. The bench drives inputs and samples outputs on falling edges, and each check is placed at the falling edge that follows the rising edge which updates the register. Burst addresses are compared one by one against a bench-side walk of the line, gap and field rules.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_ISSUE = 2'd2
    } ilv_state_e;

    localparam int BEAT_BYTES = 16;
    localparam int BEAT_SH    = $clog2(BEAT_BYTES);

    // bursts per request for a 2-bit code; reserved code maps to one
    function automatic logic [2:0] bursts_for(input logic [1:0] code);
        unique case (code)
            2'b01:   return 3'd2;
            2'b11:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/ilv_cfg_check.sv
module ilv_cfg_check #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 32
) (
    input  logic [CNT_W-1:0]  line_bytes,
    input  logic [CNT_W-1:0]  lines,
    input  logic [CNT_W-1:0]  fields,
    input  logic [BYTE_W-1:0] total,
    input  logic [1:0]        code,
    output logic              cfg_ok,
    output logic [2:0]        nbursts
);
    import ilv_pkg::*;

    localparam int MAXSH = BEAT_SH + 2;

    logic [MAXSH-1:0] align_mask;
    logic             aligned;
    logic             nonzero;

    always_comb begin
        nbursts = bursts_for(code);
        unique case (code)
            2'b01:   align_mask = MAXSH'((1 << (BEAT_SH + 1)) - 1);
            2'b11:   align_mask = MAXSH'((1 << (BEAT_SH + 2)) - 1);
            default: align_mask = MAXSH'((1 << BEAT_SH) - 1);
        endcase
        aligned = ((line_bytes[MAXSH-1:0] & align_mask) == '0);
        nonzero = (line_bytes != '0) && (lines != '0) && (fields != '0)
                  && (total[BYTE_W-1:BEAT_SH] != '0);
        cfg_ok  = aligned && nonzero;
    end
endmodule

// File: rtl/ilv_line_walker.sv
module ilv_line_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CNT_W-1:0]  line_bytes_in,
    input  logic [CNT_W-1:0]  gap_in,
    input  logic [CNT_W-1:0]  lines_in,
    output logic [ADDR_W-1:0] addr,
    output logic              field_end
);
    import ilv_pkg::*;

    logic [ADDR_W-1:0] cur_q, fbase_q;
    logic [CNT_W-1:0]  pos_q, left_q;
    logic [CNT_W-1:0]  lb_q, gap_q, lines_q;
    logic              line_end;
    logic [ADDR_W-1:0] fbase_next;

    always_comb begin
        line_end   = (pos_q == lb_q - CNT_W'(BEAT_BYTES));
        field_end  = line_end && (left_q == CNT_W'(1));
        fbase_next = fbase_q + ADDR_W'(lb_q);
        addr       = cur_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            fbase_q <= '0;
            pos_q   <= '0;
            left_q  <= '0;
            lb_q    <= '0;
            gap_q   <= '0;
            lines_q <= '0;
        end else if (load) begin
            cur_q   <= base_in;
            fbase_q <= base_in;
            pos_q   <= '0;
            left_q  <= lines_in;
            lb_q    <= line_bytes_in;
            gap_q   <= gap_in;
            lines_q <= lines_in;
        end else if (step) begin
            if (field_end) begin
                fbase_q <= fbase_next;
                cur_q   <= fbase_next;
                pos_q   <= '0;
                left_q  <= lines_q;
            end else if (line_end) begin
                cur_q   <= cur_q + ADDR_W'(BEAT_BYTES) + ADDR_W'(gap_q);
                pos_q   <= '0;
                left_q  <= left_q - CNT_W'(1);
            end else begin
                cur_q   <= cur_q + ADDR_W'(BEAT_BYTES);
                pos_q   <= pos_q + CNT_W'(BEAT_BYTES);
            end
        end
    end
endmodule

// File: rtl/ilv_frame_counters.sv
module ilv_frame_counters #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              field_end,
    input  logic [CNT_W-1:0]  fields_in,
    input  logic [BYTE_W-1:0] total_in,
    output logic              last_burst
);
    import ilv_pkg::*;

    localparam int BEATS_W = BYTE_W - BEAT_SH;

    logic [CNT_W-1:0]   fields_q;
    logic [BEATS_W-1:0] beats_q;

    always_comb begin
        last_burst = (beats_q == BEATS_W'(1))
                     || (field_end && fields_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
            beats_q  <= '0;
        end else if (load) begin
            fields_q <= fields_in;
            beats_q  <= total_in[BYTE_W-1:BEAT_SH];
        end else if (step) begin
            beats_q <= beats_q - BEATS_W'(1);
            if (field_end) fields_q <= fields_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_field_base,
    input  logic [CNT_W-1:0]  cfg_num_fields,
    input  logic [CNT_W-1:0]  cfg_lines_per_field,
    input  logic [CNT_W-1:0]  cfg_line_bytes,
    input  logic [CNT_W-1:0]  cfg_gap_bytes,
    input  logic [1:0]        cfg_burst_code,
    input  logic [BYTE_W-1:0] cfg_total_bytes,
    input  logic              start,
    input  logic              req,
    input  logic              done_clr_wr,
    input  logic              done_clr_bit,
    output logic              burst_valid,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    import ilv_pkg::*;

    ilv_state_e state_q, state_d;
    logic [2:0] nb_q, bidx_q;
    logic       done_q, err_q;
    logic       cfg_ok, load, step, field_end, last_burst;
    logic [2:0] nb_dec;
    logic       start_idle;

    ilv_cfg_check #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
        .line_bytes (cfg_line_bytes),
        .lines      (cfg_lines_per_field),
        .fields     (cfg_num_fields),
        .total      (cfg_total_bytes),
        .code       (cfg_burst_code),
        .cfg_ok     (cfg_ok),
        .nbursts    (nb_dec)
    );

    ilv_line_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .step          (step),
        .base_in       (cfg_field_base),
        .line_bytes_in (cfg_line_bytes),
        .gap_in        (cfg_gap_bytes),
        .lines_in      (cfg_lines_per_field),
        .addr          (burst_addr),
        .field_end     (field_end)
    );

    ilv_frame_counters #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .field_end  (field_end),
        .fields_in  (cfg_num_fields),
        .total_in   (cfg_total_bytes),
        .last_burst (last_burst)
    );

    assign start_idle = start && (state_q == S_IDLE);
    assign load       = start_idle && cfg_ok;
    assign step       = (state_q == S_ISSUE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (load) state_d = S_ARMED;
            S_ARMED: if (req)  state_d = S_ISSUE;
            S_ISSUE: begin
                if (last_burst)                     state_d = S_IDLE;
                else if (bidx_q == nb_q - 3'd1)     state_d = S_ARMED;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            nb_q    <= 3'd1;
            bidx_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_idle) err_q <= !cfg_ok;
            if (load) nb_q <= nb_dec;
            if (state_q == S_ARMED)     bidx_q <= '0;
            else if (step)              bidx_q <= bidx_q + 3'd1;
            if (step && last_burst)                done_q <= 1'b1;
            else if (done_clr_wr && done_clr_bit)  done_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        burst_valid = (state_q == S_ISSUE);
        busy        = (state_q != S_IDLE);
        done        = done_q;
        cfg_err     = err_q;
    end
endmodule

module ilv_addr_gen_props (
    input logic clk,
    input logic rst_n,
    input logic burst_valid,
    input logic busy,
    input logic done,
    input logic cfg_err,
    input logic done_clr_wr,
    input logic done_clr_bit
);
    // R10: no burst when idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !burst_valid);
    // R8: done rises together with busy falling
    a_r8_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
    // R9: a rejected start leaves the channel idle
    a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);
    // R8: writing zero keeps done
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_clr_wr && !done_clr_bit) |=> done);
    // R8: writing one clears done when idle
    a_r8_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_wr && done_clr_bit && !busy) |=> !done);
endmodule

bind ilv_addr_gen ilv_addr_gen_props u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_valid  (burst_valid),
    .busy         (busy),
    .done         (done),
    .cfg_err      (cfg_err),
    .done_clr_wr  (done_clr_wr),
    .done_clr_bit (done_clr_bit)
);

// File: tb/ilv_addr_gen_test.sv
module ilv_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_field_base = '0;
    logic [15:0] cfg_num_fields = '0;
    logic [15:0] cfg_lines_per_field = '0;
    logic [15:0] cfg_line_bytes = '0;
    logic [15:0] cfg_gap_bytes = '0;
    logic [1:0]  cfg_burst_code = '0;
    logic [31:0] cfg_total_bytes = '0;
    logic        start = 1'b0, req = 1'b0, done_clr_wr = 1'b0, done_clr_bit = 1'b0;
    logic        burst_valid, busy, done, cfg_err;
    logic [31:0] burst_addr;

    int vectors = 0;
    int errors  = 0;

    // bench-side expectation state
    logic [31:0] m_addr, m_fbase;
    int          m_pos, m_left, m_fields, m_beats, m_lb, m_gap, m_lines;
    bit          m_done;

    always #2 clk = ~clk;

    ilv_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_field_base(cfg_field_base), .cfg_num_fields(cfg_num_fields),
        .cfg_lines_per_field(cfg_lines_per_field), .cfg_line_bytes(cfg_line_bytes),
        .cfg_gap_bytes(cfg_gap_bytes), .cfg_burst_code(cfg_burst_code),
        .cfg_total_bytes(cfg_total_bytes), .start(start), .req(req),
        .done_clr_wr(done_clr_wr), .done_clr_bit(done_clr_bit),
        .burst_valid(burst_valid), .burst_addr(burst_addr),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [31:0] base, input int lb, input int gap,
                           input int lines, input int fields, input logic [1:0] code,
                           input int total);
        cfg_field_base = base; cfg_line_bytes = 16'(lb); cfg_gap_bytes = 16'(gap);
        cfg_lines_per_field = 16'(lines); cfg_num_fields = 16'(fields);
        cfg_burst_code = code; cfg_total_bytes = 32'(total);
        m_addr = base; m_fbase = base; m_pos = 0; m_left = lines; m_fields = fields;
        m_beats = total / 16; m_lb = lb; m_gap = gap; m_lines = lines; m_done = 0;
    endtask

    task automatic model_step();
        bit line_end, field_end;
        line_end  = (m_pos + 16 == m_lb);
        field_end = line_end && (m_left == 1);
        m_beats--;
        if (m_beats == 0) m_done = 1;
        if (field_end) begin
            m_fbase += 32'(m_lb); m_addr = m_fbase; m_pos = 0; m_left = m_lines;
            m_fields--;
            if (m_fields == 0) m_done = 1;
        end else if (line_end) begin
            m_addr += 32'(16 + m_gap); m_pos = 0; m_left--;
        end else begin
            m_addr += 32'd16; m_pos += 16;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // one request; nb bursts unless the transfer ends first
    task automatic one_request(input string tag, input int nb, input bit poke_req);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        for (int k = 0; k < nb; k++) begin
            check({tag, " R2 valid"}, 32'(burst_valid), 32'd1);
            check({tag, " R3/R4/R5 addr"}, burst_addr, m_addr);
            model_step();
            if (poke_req && k == 0) req = 1'b1; // R10: request mid-issue
            if (m_done) begin
                @(negedge clk); req = 1'b0;
                break;
            end
            @(negedge clk); req = 1'b0;
        end
        check({tag, " R2 stop"}, 32'(burst_valid), 32'd0);
        if (m_done) begin
            check({tag, " R8 done"}, 32'(done), 32'd1);
            check({tag, " R6/R7 busy low"}, 32'(busy), 32'd0);
        end else begin
            check({tag, " R1 busy held"}, 32'(busy), 32'd1);
            @(negedge clk);
            check({tag, " R10 no extra burst"}, 32'(burst_valid), 32'd0);
        end
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr_wr = 1'b1; done_clr_bit = 1'b1;
        @(negedge clk); done_clr_wr = 1'b0; done_clr_bit = 1'b0;
    endtask

    task automatic run_frame(input string tag, input int nb, input bit poke_first,
                             input int max_req);
        pulse_start();
        check({tag, " R1 busy"}, 32'(busy), 32'd1);
        check({tag, " R9 no err"}, 32'(cfg_err), 32'd0);
        for (int r = 0; r < max_req && !m_done; r++)
            one_request(tag, nb, poke_first && r == 0);
        check({tag, " R6/R7 finished"}, 32'(m_done), 32'd1);
        clear_done();
    endtask

    task automatic t_reset();
        check("reset R1 busy", 32'(busy), 32'd0);
        check("reset R8 done", 32'(done), 32'd0);
        check("reset R9 err", 32'(cfg_err), 32'd0);
        check("reset R10 valid", 32'(burst_valid), 32'd0);
    endtask

    task automatic t_idle_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        check("idle R10 no burst", 32'(burst_valid), 32'd0);
        check("idle R10 busy", 32'(busy), 32'd0);
    endtask

    task automatic t_single_fields();
        // two fields of two 32-byte lines, gap 16: fields end the transfer (R6)
        set_cfg(32'h0000_1000, 32, 16, 2, 2, 2'b00, 32'h1000);
        run_frame("one-burst", 1, 1'b0, 20);
    endtask

    task automatic t_double_bytes();
        // bytes end the transfer after 16 bursts (R7); request during issue ignored
        set_cfg(32'h8000_0000, 64, 64, 3, 2, 2'b01, 256);
        run_frame("two-burst", 2, 1'b1, 20);
    endtask

    task automatic t_quad_mid();
        // 48 bytes: transfer ends in the middle of a four-burst request (R7)
        set_cfg(32'h0004_0000, 64, 0, 1, 4, 2'b11, 48);
        run_frame("four-burst", 4, 1'b0, 4);
    endtask

    task automatic t_reserved();
        set_cfg(32'h0000_2200, 16, 32, 2, 1, 2'b10, 64);
        run_frame("reserved", 1, 1'b0, 6);
    endtask

    task automatic t_cfg_err();
        set_cfg(32'h0, 48, 0, 1, 1, 2'b01, 64);
        pulse_start();
        check("err48 R9 cfg_err", 32'(cfg_err), 32'd1);
        check("err48 R9 busy", 32'(busy), 32'd0);
        t_idle_req();
        set_cfg(32'h0, 32, 0, 1, 1, 2'b11, 64);
        pulse_start();
        check("err32q R9 cfg_err", 32'(cfg_err), 32'd1);
        set_cfg(32'h0, 32, 0, 1, 1, 2'b00, 8);
        pulse_start();
        check("errtot R9 cfg_err", 32'(cfg_err), 32'd1);
        set_cfg(32'h0000_0300, 32, 0, 1, 1, 2'b00, 32);
        pulse_start();
        check("good R9 err cleared", 32'(cfg_err), 32'd0);
        check("good R1 busy", 32'(busy), 32'd1);
        one_request("good", 1, 1'b0);
        one_request("good", 1, 1'b0);
        check("good R8 done", 32'(done), 32'd1);
    endtask

    task automatic t_w1c();
        @(negedge clk); done_clr_wr = 1'b1; done_clr_bit = 1'b0;
        @(negedge clk); done_clr_wr = 1'b0;
        check("w1c R8 zero keeps", 32'(done), 32'd1);
        clear_done();
        check("w1c R8 one clears", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_req();
        t_single_fields();
        t_double_bytes();
        t_quad_mid();
        t_reserved();
        t_cfg_err();
        t_w1c();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule